// File: doc/BRIEF.md
# Interrupt Source Controller

This block is the source half of a two-level interrupt controller. It keeps a table of `NUM_SRC` interrupt sources. Each source has a destination server, a priority, a saved priority, a type (level or message) and a set of status bits. Level sources follow their input line. A message source treats a one-cycle high on its line as one event. A source that is ready is queued for delivery. The block then presents one offer at a time, made of server, global number and priority, to a presentation controller through a valid/acknowledge handshake.

The presentation side answers asynchronously with three inputs. A reject, addressed by global number, is sent when the offer could not be taken. An end-of-interrupt is sent when the handler finishes. A resend asks every source to re-evaluate. An event that is masked or rejected is not dropped. It is kept in a status bit and replayed later by an unmask through the configuration port, by a resend, or (for level sources) by a later resend after an end-of-interrupt.

Top module: `irq_source_ctrl`

## Requirements
- R1: An offer carries global number `BASE_NUM + index`, together with the server and priority stored for that source when the offer was granted. Configuration writes set server, priority and saved priority per source.
- R2: A priority of all ones (0xFF) masks a source. A message event on an unmasked source queues an offer. On a masked source it sets a masked-pending bit instead and nothing is offered.
- R3: For a level source, the asserted bit follows the line. An offer check runs when the line changes, on a configuration write and on a resend. If the source is unmasked, asserted and not yet sent, the check queues an offer and sets the sent bit.
- R4: A reject addressed to a message source sets its rejected bit. A reject addressed to a level source clears its sent bit. Neither produces an offer by itself.
- R5: A resend re-runs the level offer check on every level source. It also clears the rejected bit of every message source that has it set, and re-offers that source if it is unmasked.
- R6: An end-of-interrupt clears the sent bit of a level source and has no effect on a message source. It produces no offer by itself.
- R7: A configuration write that unmasks a masked-pending message source clears the bit and queues an offer.
- R8: A synchronous reset sets every priority and saved priority to 0xFF, clears the server, status and queue, and drops the offer. It keeps every source's type.
- R9: Each source's type can be set once (type write with `type_lvl` 1 = level, 0 = message). Later type writes are ignored. A source with no type ignores its line.
- R10: Only one offer is outstanding. It holds until `offer_ack`. Queued sources are granted round-robin, starting after the last granted index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_line | input | NUM_SRC | Per-source line: a level, or a one-cycle event pulse |
| type_we | input | 1 | Type write strobe |
| type_idx | input | IDX_W | Source index for type write |
| type_lvl | input | 1 | 1 = level, 0 = message |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Source index for configuration write |
| cfg_server | input | SRV_W | Destination server |
| cfg_prio | input | PRIO_W | Priority (all ones = masked) |
| cfg_saved | input | PRIO_W | Saved priority |
| rej_valid | input | 1 | Reject strobe |
| rej_gnum | input | GNUM_W | Global number being rejected |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_gnum | input | GNUM_W | Global number being completed |
| resend | input | 1 | Resend-all strobe |
| offer_valid | output | 1 | Offer outstanding |
| offer_server | output | SRV_W | Server of the offer |
| offer_gnum | output | GNUM_W | Global number of the offer |
| offer_prio | output | PRIO_W | Priority of the offer |
| offer_saved | output | PRIO_W | Saved priority of the offered source |
| offer_ack | input | 1 | Presentation side takes the offer |

## Verification
Any stimulus that queues an offer (line event, configuration write or resend pulse) changes source state on the first clock edge. The offer register loads on the second edge, so with nothing outstanding the offer is due two cycles after the stimulus is driven. After the acknowledging edge, `offer_valid` is low for exactly one cycle, and the next queued source is presented on the edge after that. The bench drives inputs just after a falling edge and samples on the falling edge where each result is due. It checks that no offer appears several cycles after every stimulus that must not produce one.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
  typedef struct packed {
    logic asserted;  // level: line state
    logic sent;      // level: offered, not yet completed
    logic rejected;  // message: bounced, waiting for resend
    logic mpend;     // message: event arrived while masked
    logic pend;      // queued for the offer arbiter
  } src_stat_t;
endpackage

// File: rtl/irq_src_entry.sv
module irq_src_entry
  import irq_src_pkg::*;
#(
  parameter int SRV_W  = 4,
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line,
  input  logic              cfg_hit,
  input  logic [SRV_W-1:0]  cfg_server,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic [PRIO_W-1:0] cfg_saved,
  input  logic              type_hit,
  input  logic              type_lvl,
  input  logic              rej_hit,
  input  logic              eoi_hit,
  input  logic              resend,
  input  logic              ack_hit,
  output logic              pend,
  output logic [SRV_W-1:0]  server,
  output logic [PRIO_W-1:0] prio,
  output logic [PRIO_W-1:0] saved
);
  localparam logic [PRIO_W-1:0] MASKED = '1;

  // type survives reset: power-up value only
  logic typed  = 1'b0;
  logic is_lvl = 1'b0;

  src_stat_t         st, st_n;
  logic [SRV_W-1:0]  srv_n;
  logic [PRIO_W-1:0] pr_n, sv_n;
  logic              unmasked, chk;

  always_ff @(posedge clk) begin
    if (type_hit && !typed) begin
      typed  <= 1'b1;
      is_lvl <= type_lvl;
    end
  end

  always_comb begin
    st_n  = st;
    srv_n = server;
    pr_n  = prio;
    sv_n  = saved;
    chk   = 1'b0;
    if (ack_hit) st_n.pend = 1'b0;
    if (cfg_hit) begin
      srv_n = cfg_server;
      pr_n  = cfg_prio;
      sv_n  = cfg_saved;
    end
    unmasked = (pr_n != MASKED);
    if (typed) begin
      if (is_lvl) begin
        st_n.asserted = line;
        if (rej_hit || eoi_hit) st_n.sent = 1'b0;
        chk = (line != st.asserted) || cfg_hit || resend;
        if (chk && unmasked && line && !st_n.sent) begin
          st_n.sent = 1'b1;
          st_n.pend = 1'b1;
        end
      end else begin
        if (rej_hit) st_n.rejected = 1'b1;
        if (line) begin
          if (unmasked) st_n.pend  = 1'b1;
          else          st_n.mpend = 1'b1;
        end
        if (cfg_hit && st_n.mpend && unmasked) begin
          st_n.mpend = 1'b0;
          st_n.pend  = 1'b1;
        end
        if (resend && st_n.rejected) begin
          st_n.rejected = 1'b0;
          if (unmasked) st_n.pend = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= '0;
      server <= '0;
      prio   <= MASKED;
      saved  <= MASKED;
    end else begin
      st     <= st_n;
      server <= srv_n;
      prio   <= pr_n;
      saved  <= sv_n;
    end
  end

  assign pend = st.pend;

  AST_MPEND_MASKED: assert property (@(posedge clk) disable iff (rst)
    $rose(st.mpend) |-> prio == MASKED); // R2
  AST_SENT_UNMASKED: assert property (@(posedge clk) disable iff (rst)
    $rose(st.sent) |-> (prio != MASKED && st.asserted)); // R3
endmodule

// File: rtl/irq_offer_arb.sv
module irq_offer_arb #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     pend,
  input  logic             busy,
  output logic             grant,
  output logic [IDX_W-1:0] grant_idx
);
  logic [IDX_W-1:0] ptr;
  logic             found;
  int               j;

  always_comb begin
    found     = 1'b0;
    grant_idx = '0;
    j         = 0;
    for (int k = 0; k < N; k++) begin
      j = (int'(ptr) + k) % N;
      if (!found && pend[j]) begin
        found     = 1'b1;
        grant_idx = IDX_W'(j);
      end
    end
  end

  assign grant = found && !busy;

  always_ff @(posedge clk) begin
    if (rst)        ptr <= '0;
    else if (grant) ptr <= IDX_W'((int'(grant_idx) + 1) % N);
  end

  AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (rst)
    grant |-> pend[grant_idx]); // R10
endmodule

// File: rtl/irq_source_ctrl.sv
module irq_source_ctrl #(
  parameter  int NUM_SRC  = 16,
  parameter  int SRV_W    = 4,
  parameter  int PRIO_W   = 8,
  parameter  int GNUM_W   = 12,
  parameter  int BASE_NUM = 64,
  localparam int IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_line,
  input  logic               type_we,
  input  logic [IDX_W-1:0]   type_idx,
  input  logic               type_lvl,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [SRV_W-1:0]   cfg_server,
  input  logic [PRIO_W-1:0]  cfg_prio,
  input  logic [PRIO_W-1:0]  cfg_saved,
  input  logic               rej_valid,
  input  logic [GNUM_W-1:0]  rej_gnum,
  input  logic               eoi_valid,
  input  logic [GNUM_W-1:0]  eoi_gnum,
  input  logic               resend,
  output logic               offer_valid,
  output logic [SRV_W-1:0]   offer_server,
  output logic [GNUM_W-1:0]  offer_gnum,
  output logic [PRIO_W-1:0]  offer_prio,
  output logic [PRIO_W-1:0]  offer_saved,
  input  logic               offer_ack
);
  localparam logic [GNUM_W-1:0] GBASE = GNUM_W'(BASE_NUM);
  localparam logic [GNUM_W-1:0] GLAST = GNUM_W'(BASE_NUM + NUM_SRC - 1);

  logic [NUM_SRC-1:0] pend;
  logic [SRV_W-1:0]   srv_arr [NUM_SRC];
  logic [PRIO_W-1:0]  pr_arr  [NUM_SRC];
  logic [PRIO_W-1:0]  sv_arr  [NUM_SRC];
  logic [IDX_W-1:0]   cur_idx;
  logic               grant;
  logic [IDX_W-1:0]   grant_idx;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam logic [GNUM_W-1:0] MY_G = GNUM_W'(BASE_NUM + i);
    localparam logic [IDX_W-1:0]  MY_I = IDX_W'(i);
    irq_src_entry #(.SRV_W(SRV_W), .PRIO_W(PRIO_W)) u_ent (
      .clk        (clk),
      .rst        (rst),
      .line       (src_line[i]),
      .cfg_hit    (cfg_we && cfg_idx == MY_I),
      .cfg_server (cfg_server),
      .cfg_prio   (cfg_prio),
      .cfg_saved  (cfg_saved),
      .type_hit   (type_we && type_idx == MY_I),
      .type_lvl   (type_lvl),
      .rej_hit    (rej_valid && rej_gnum == MY_G),
      .eoi_hit    (eoi_valid && eoi_gnum == MY_G),
      .resend     (resend),
      .ack_hit    (offer_valid && offer_ack && cur_idx == MY_I),
      .pend       (pend[i]),
      .server     (srv_arr[i]),
      .prio       (pr_arr[i]),
      .saved      (sv_arr[i])
    );
  end

  irq_offer_arb #(.N(NUM_SRC), .IDX_W(IDX_W)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .pend      (pend),
    .busy      (offer_valid),
    .grant     (grant),
    .grant_idx (grant_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      offer_valid  <= 1'b0;
      cur_idx      <= '0;
      offer_server <= '0;
      offer_gnum   <= '0;
      offer_prio   <= '0;
      offer_saved  <= '0;
    end else if (offer_valid) begin
      if (offer_ack) offer_valid <= 1'b0;
    end else if (grant) begin
      offer_valid  <= 1'b1;
      cur_idx      <= grant_idx;
      offer_server <= srv_arr[grant_idx];
      offer_prio   <= pr_arr[grant_idx];
      offer_saved  <= sv_arr[grant_idx];
      offer_gnum   <= GBASE + GNUM_W'(grant_idx);
    end
  end

  AST_GNUM_RANGE: assert property (@(posedge clk) disable iff (rst)
    offer_valid |-> (offer_gnum >= GBASE && offer_gnum <= GLAST)); // R1
  AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (offer_valid && !offer_ack) |=> (offer_valid && $stable(offer_gnum) && $stable(offer_prio))); // R10
  AST_RST_IDLE: assert property (@(posedge clk)
    rst |=> !offer_valid); // R8
endmodule

// File: tb/irq_source_ctrl_bench.sv
module irq_source_ctrl_bench;
  localparam int N = 16, SW = 4, PW = 8, GW = 12, BASE = 64, IW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]  src_line = '0;
  logic          type_we = 0, type_lvl = 0;
  logic [IW-1:0] type_idx = '0;
  logic          cfg_we = 0;
  logic [IW-1:0] cfg_idx = '0;
  logic [SW-1:0] cfg_server = '0;
  logic [PW-1:0] cfg_prio = '0, cfg_saved = '0;
  logic          rej_valid = 0, eoi_valid = 0, resend = 0, offer_ack = 0;
  logic [GW-1:0] rej_gnum = '0, eoi_gnum = '0;
  logic          offer_valid;
  logic [SW-1:0] offer_server;
  logic [GW-1:0] offer_gnum;
  logic [PW-1:0] offer_prio, offer_saved;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  irq_source_ctrl #(.NUM_SRC(N), .SRV_W(SW), .PRIO_W(PW), .GNUM_W(GW), .BASE_NUM(BASE)) u_irq_source_ctrl (
    .clk(clk), .rst(rst), .src_line(src_line),
    .type_we(type_we), .type_idx(type_idx), .type_lvl(type_lvl),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_server(cfg_server),
    .cfg_prio(cfg_prio), .cfg_saved(cfg_saved),
    .rej_valid(rej_valid), .rej_gnum(rej_gnum),
    .eoi_valid(eoi_valid), .eoi_gnum(eoi_gnum), .resend(resend),
    .offer_valid(offer_valid), .offer_server(offer_server), .offer_gnum(offer_gnum),
    .offer_prio(offer_prio), .offer_saved(offer_saved), .offer_ack(offer_ack)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_type(int i, bit lvl);
    type_idx = IW'(i); type_lvl = lvl; type_we = 1; tick(); type_we = 0; tick();
  endtask

  task automatic cfg(int i, int srv, int pr);
    cfg_idx = IW'(i); cfg_server = SW'(srv); cfg_prio = PW'(pr); cfg_saved = PW'(8'h80 + i);
    cfg_we = 1; tick(); cfg_we = 0; tick();
  endtask

  task automatic pulse_src(logic [N-1:0] m);
    src_line = src_line | m; tick(); src_line = src_line & ~m; tick();
  endtask

  task automatic do_resend();
    resend = 1; tick(); resend = 0; tick();
  endtask

  task automatic do_reject(int i);
    rej_gnum = GW'(BASE + i); rej_valid = 1; tick(); rej_valid = 0; tick();
  endtask

  task automatic do_eoi(int i);
    eoi_gnum = GW'(BASE + i); eoi_valid = 1; tick(); eoi_valid = 0; tick();
  endtask

  task automatic expect_offer(int i, int srv, int pr, string req);
    chk_eq(req, "offer_valid", int'(offer_valid), 1);
    chk_eq(req, "offer_gnum", int'(offer_gnum), BASE + i);
    chk_eq(req, "offer_server", int'(offer_server), srv);
    chk_eq(req, "offer_prio", int'(offer_prio), pr);
    offer_ack = 1; tick(); offer_ack = 0;
    chk_eq("R10", "valid after ack", int'(offer_valid), 0);
  endtask

  task automatic expect_none(string req);
    repeat (3) tick();
    chk_eq(req, "no offer", int'(offer_valid), 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    tick(); tick(); rst = 0; tick();
    chk_eq("R8", "reset offer_valid", int'(offer_valid), 0);

    // types: even = level, odd = message, 15 untyped
    for (int i = 0; i < 15; i++) set_type(i, (i % 2) == 0);
    set_type(0, 1'b0); // R9: second write ignored
    for (int i = 0; i < N; i++) cfg(i, i % 4, 8'h10 + i);
    expect_none("R1");

    // R2/R1: message sweep
    for (int i = 1; i < 15; i += 2) begin
      pulse_src(N'(1) << i);
      expect_offer(i, i % 4, 8'h10 + i, "R2");
    end
    // R9: untyped ignored
    pulse_src(N'(1) << 15);
    expect_none("R9");

    // R2/R7: masked then unmasked
    cfg(1, 1, 8'hFF);
    pulse_src(N'(1) << 1);
    expect_none("R2");
    cfg(1, 1, 8'h21);
    expect_offer(1, 1, 8'h21, "R7");

    // R3/R4/R5/R6: level source 2
    src_line[2] = 1; tick(); tick();
    expect_offer(2, 2, 8'h12, "R3");
    expect_none("R3");
    do_eoi(2);
    expect_none("R6");
    do_resend();
    expect_offer(2, 2, 8'h12, "R5");
    do_reject(2);
    expect_none("R4");
    do_resend();
    expect_offer(2, 2, 8'h12, "R4");
    src_line[2] = 0; tick(); tick();
    do_resend();
    expect_none("R5");

    // R4/R5/R6: message source 3
    pulse_src(N'(1) << 3);
    expect_offer(3, 3, 8'h13, "R2");
    do_reject(3);
    expect_none("R4");
    do_resend();
    expect_offer(3, 3, 8'h13, "R5");
    do_resend();
    expect_none("R5");
    do_eoi(3);
    do_resend();
    expect_none("R6");

    // R9: source 0 stayed level
    pulse_src(N'(1) << 0);
    expect_offer(0, 0, 8'h10, "R9");
    do_reject(0);
    do_resend();
    expect_none("R9");

    // R10: round robin, pointer now after index 0
    pulse_src((N'(1) << 5) | (N'(1) << 7) | (N'(1) << 9));
    expect_offer(5, 1, 8'h15, "R10");
    tick();
    expect_offer(7, 3, 8'h17, "R10");
    tick();
    expect_offer(9, 1, 8'h19, "R10");
    pulse_src((N'(1) << 3) | (N'(1) << 11));
    expect_offer(11, 3, 8'h1B, "R10");
    tick();
    expect_offer(3, 3, 8'h13, "R10");

    // R8: reset keeps type, masks everything
    rst = 1; tick(); rst = 0; tick();
    chk_eq("R8", "offer after reset", int'(offer_valid), 0);
    pulse_src(N'(1) << 3);
    expect_none("R8");
    src_line[2] = 1; tick(); tick();
    expect_none("R8");
    cfg(2, 3, 8'h30);
    expect_offer(2, 3, 8'h30, "R8");
    cfg(3, 1, 8'h31);
    expect_offer(3, 1, 8'h31, "R7");
    src_line[2] = 0; tick();

    summary();
    $finish;
  end
endmodule